// File: doc/BRIEF.md
# Fractional microsecond tick counter

The block divides a reference clock by a programmable rational ratio and emits a one-cycle tick at 1 MHz. Each tick also advances a free-running microsecond counter that software reads over a small register bus. A tick output goes to downstream timers.

The ratio comes from a 16-bit configuration word. The low byte N and the high byte M are both encoded as value+1, and one tick is produced for every (N+1)/(M+1) reference cycles. An accumulator adds M+1 on every cycle and subtracts N+1 whenever the sum reaches N+1. This spreads the ticks evenly, so non-integer ratios such as 64/5 for a 12.8 MHz reference are exact over each period of N+1 cycles. Typical settings are 0x000B for 12 MHz, 0x0019 for 26 MHz, 0x043F for 12.8 MHz and 0x045F for 19.2 MHz.

The bus has one select line, a write strobe and a one-bit address. Address 0 reads the counter. Address 1 writes the configuration and reads it back.

Top module: `usec_tick_counter`

## Requirements
- R1: After reset the configuration reads 0x000B, the counter reads 0 and tick_o is low.
- R2: The configuration low byte [7:0] is N and the high byte [15:8] is M. When M < N and the accumulator was cleared by a write at edge W, the number of ticks over edges W+1..W+t is floor(t*(M+1)/(N+1)). So 0x000B ticks on every 12th edge, and 0x043F gives 5 ticks in every 64 edges.
- R3: Successive ticks are separated by either floor or ceil of (N+1)/(M+1) cycles.
- R4: tick_o is high for one cycle per tick. The counter increments by exactly 1 at each tick and holds its value otherwise.
- R5: The counter is CNT_W bits wide (32 by default). It wraps from all ones to 0 with no stall.
- R6: A configuration write clears the accumulator and keeps the counter value. No tick is produced on the write edge, and the new ratio applies from the next edge.
- R7: A configuration with M >= N gives one tick on every cycle and never more than one.
- R8: A read of address 0 returns, one cycle after the read edge, the full counter value as it stood just before that edge, zero-extended. A read of address 1 returns the configuration zero-extended. bus_rdata_o holds its value between reads.
- R9: A write to address 0 has no effect on the counter, the configuration or the tick sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, also the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 1 | 0 = counter, 1 = configuration |
| bus_wdata_i | input | 16 | Write data {M, N} |
| bus_rdata_o | output | DATA_W | Registered read data |
| tick_o | output | 1 | One-cycle 1 MHz tick pulse |

## Verification
tick_o and the counter both change on the edge at which the accumulator reaches N+1. The bench therefore samples tick_o at the falling edge after each rising edge and compares it with floor(t*(M+1)/(N+1)) - floor((t-1)*(M+1)/(N+1)) for edge t after the configuration write. Read data is due one cycle after the read edge and reflects the counter before that edge. Counter deltas are predicted from the number of edges between the write and each read. A second instance with an 8-bit counter reaches the wrap point within a few hundred cycles.

// File: rtl/utc_pkg.sv
package utc_pkg;
  localparam int FIELD_W = 8;
  localparam int CFG_W   = 2 * FIELD_W;
  localparam logic [CFG_W-1:0] CFG_RST = 16'h000B;
  localparam logic ADDR_CNT = 1'b0;
  localparam logic ADDR_CFG = 1'b1;

  typedef struct packed {
    logic [FIELD_W-1:0] m;
    logic [FIELD_W-1:0] n;
  } cfg_t;
endpackage

// File: rtl/utc_ratio_decode.sv
module utc_ratio_decode
  import utc_pkg::*;
(
  input  cfg_t             cfg_i,
  output logic [FIELD_W:0] num_o,
  output logic [FIELD_W:0] inc_o
);
  logic [FIELD_W:0] inc_raw;

  always_comb begin
    num_o   = {1'b0, cfg_i.n} + 1'b1;
    inc_raw = {1'b0, cfg_i.m} + 1'b1;
    // clamp to at most one tick per cycle
    inc_o   = (cfg_i.m >= cfg_i.n) ? num_o : inc_raw;
  end
endmodule

// File: rtl/utc_accum.sv
module utc_accum #(
  parameter int FW = 8,
  localparam int ACC_W = FW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] num_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic             tick_d_o,
  output logic             tick_o,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic [ACC_W:0]   rem;

  always_comb begin
    sum      = {1'b0, acc_q} + {1'b0, inc_i};
    rem      = sum - {1'b0, num_i};
    tick_d_o = !clr_i && (sum >= {1'b0, num_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (clr_i) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      acc_q  <= tick_d_o ? rem[ACC_W-1:0] : sum[ACC_W-1:0];
      tick_o <= tick_d_o;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/utc_counter.sv
module utc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/usec_tick_counter.sv
module usec_tick_counter
  import utc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic              bus_addr_i,
  input  logic [CFG_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              tick_o
);
  localparam int ACC_W = FIELD_W + 1;

  cfg_t             cfg_q;
  logic             cfg_wr;
  logic             rd_en;
  logic [ACC_W-1:0] num_w;
  logic [ACC_W-1:0] inc_w;
  logic [ACC_W-1:0] acc_w;
  logic             tick_d;
  logic [CNT_W-1:0] cnt_w;
  logic [DATA_W-1:0] rdata_d;

  assign cfg_wr = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_CFG);
  assign rd_en  = bus_sel_i && !bus_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= cfg_t'(CFG_RST);
    else if (cfg_wr) cfg_q <= cfg_t'(bus_wdata_i);
  end

  utc_ratio_decode u_dec (
    .cfg_i (cfg_q),
    .num_o (num_w),
    .inc_o (inc_w)
  );

  utc_accum #(.FW(FIELD_W)) u_accum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cfg_wr),
    .num_i    (num_w),
    .inc_i    (inc_w),
    .tick_d_o (tick_d),
    .tick_o   (tick_o),
    .acc_o    (acc_w)
  );

  utc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (tick_d),
    .cnt_o  (cnt_w)
  );

  always_comb begin
    rdata_d = '0;
    if (bus_addr_i == ADDR_CFG) rdata_d[CFG_W-1:0] = cfg_q;
    else                        rdata_d[CNT_W-1:0] = cnt_w;
  end

  // whole word captured on one edge: no tearing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bus_rdata_o <= '0;
    else if (rd_en) bus_rdata_o <= rdata_d;
  end
endmodule

// File: rtl/utc_chk.sv
module utc_chk #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic              bus_addr_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              tick_o,
  input logic [15:0]       cfg_i,
  input logic [8:0]        acc_i,
  input logic [CNT_W-1:0]  cnt_i
);
  logic [8:0] num_chk;
  assign num_chk = {1'b0, cfg_i[7:0]} + 9'd1;

  // R4
  tick_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> cnt_i == CNT_W'($past(cnt_i) + 1'b1));

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |-> $stable(cnt_i));

  // R6
  cfg_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && bus_we_i && bus_addr_i) |=> (!tick_o && $stable(cnt_i)));

  // R8
  rd_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && !bus_we_i && !bus_addr_i) |=> bus_rdata_o == DATA_W'($past(cnt_i)));

  // R8
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_sel_i |=> $stable(bus_rdata_o));

  // R2
  acc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i < num_chk);
endmodule

bind usec_tick_counter utc_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_sel_i   (bus_sel_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .tick_o      (tick_o),
  .cfg_i       (cfg_q),
  .acc_i       (acc_w),
  .cnt_i       (cnt_w)
);

// File: tb/usec_tick_counter_bench.sv
module usec_tick_counter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic        addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] rdata_n;
  logic        tick;
  logic        tick_n;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usec_tick_counter u_usec_tick_counter (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tick_o(tick)
  );

  usec_tick_counter #(.CNT_W(8)) u_usec_tick_counter_narrow (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_n), .tick_o(tick_n)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic bus_write(input logic a, input logic [15:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    d = rdata;
  endtask

  function automatic int ticks_upto(input int t, input logic [15:0] cfg);
    int n = int'(cfg[7:0]) + 1;
    int m = int'(cfg[15:8]) + 1;
    int inc = (cfg[15:8] >= cfg[7:0]) ? n : m;
    return (t * inc) / n;
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    check("R1 tick", tick, 0);
    bus_read(1'b1, v);
    check("R1 cfg", v, 32'h000B);
    bus_read(1'b0, v);
    check("R1 cnt", v, 0);
  endtask

  task automatic t_ratio(input logic [15:0] cfg, input int len, input string req);
    logic [31:0] c_pre, c0, c1, v;
    logic t_pre;
    int last, bad, gmin, gmax, n, m;
    n = int'(cfg[7:0]) + 1;
    m = (cfg[15:8] >= cfg[7:0]) ? n : int'(cfg[15:8]) + 1;
    gmin = n / m;
    gmax = (n + m - 1) / m;
    bus_read(1'b0, c_pre);
    t_pre = tick;
    bus_write(1'b1, cfg);
    check({req, " R6 no tick on write"}, tick, 0);
    bus_read(1'b0, c0);
    check({req, " R6 count kept"}, c0, 32'(c_pre + 32'(t_pre)));
    bad = 0; last = 0;
    for (int t = 1; t <= len; t++) begin
      if (t > 1) @(negedge clk);
      if (tick != ((ticks_upto(t, cfg) - ticks_upto(t - 1, cfg)) != 0)) bad++;
      if (tick) begin
        if (last > 0 && (t - last < gmin || t - last > gmax)) bad++;
        last = t;
      end
    end
    check({req, " R2 R3 R7 tick pattern errors"}, bad, 0);
    bus_read(1'b0, c1);
    check({req, " R4 count delta"}, c1 - c0, ticks_upto(len, cfg));
    bus_read(1'b1, v);
    check({req, " R8 cfg readback"}, v, {16'h0, cfg});
  endtask

  task automatic t_cnt_write;
    logic [31:0] a, b, v;
    bus_write(1'b1, 16'h0000);
    bus_read(1'b0, a);
    bus_write(1'b0, 16'h1234);
    check("R9 tick after addr0 write", tick, 1);
    bus_read(1'b0, b);
    check("R9 count after addr0 write", b, a + 2);
    bus_read(1'b1, v);
    check("R9 cfg after addr0 write", v, 0);
  endtask

  task automatic t_wrap;
    logic [31:0] a, b;
    bus_write(1'b1, 16'h0000);
    bus_read(1'b0, a);
    a = rdata_n;
    repeat (299) @(negedge clk);
    bus_read(1'b0, b);
    b = rdata_n;
    check("R5 narrow wrap", b, (a + 300) % 256);
    check("R5 narrow upper zero", b >> 8, 0);
    check("R4 narrow tick", tick_n, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ratio(16'h000B, 48,  "12M");
    t_ratio(16'h043F, 128, "12M8");
    t_ratio(16'h045F, 192, "19M2");
    t_ratio(16'h04BF, 192, "38M4");
    t_ratio(16'h0019, 52,  "26M");
    t_ratio(16'h0503, 20,  "clamp gt");
    t_ratio(16'h0202, 20,  "clamp eq");
    t_cnt_write();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule